// File: doc/BRIEF.md
# Extended Interrupt Cause Controller

This block gathers interrupt causes for a network interface that has several queues. It captures each event in a 32-bit cause register. Each receive queue and each transmit queue has its own event pulse. A timer-expiry pulse has its own bit. A level input reports that some legacy cause is pending. Software reaches the block through a small register port. It can force causes through a write-only set register, enable or disable each cause through a pair of mask registers, and choose which causes clear themselves once the interrupt has fired.

A cause bit can be cleared in three ways: by writing 1 to it, by reading the cause register, or by auto-clear after the interrupt is raised. A hardware event always beats a clear that lands in the same cycle, so no event is lost. The interrupt output is a registered level. It is high while any enabled cause bit is set.

Register word addresses on `reg_addr`: 0 cause (read clears, write 1 clears), 1 cause set (write only), 2 mask set (a read returns the mask), 3 mask clear (write only), 4 auto-clear enable (read/write). Write-only addresses read as zero.

Top module: `intr_cause_ctrl`

## Requirements
- R1: After reset the cause register, the mask, the auto-clear enable and `irq` are all 0, and every register reads 0.
- R2: A pulse on `rx_evt[q]` sets cause bit q. A pulse on `tx_evt[q]` sets bit 8+q. `tmr_evt` sets bit 30. `legacy_active` high sets bit 31. The new value is visible to a read that starts on the following cycle.
- R3: Bits 4..7 and 12..29 (and any queue bit beyond NUM_RXQ/NUM_TXQ) are never set in the cause, mask or auto-clear registers, and they read as 0.
- R4: Writing address 0 clears every cause bit written as 1. Bits written as 0 keep their value.
- R5: A read of address 0 returns the cause value on `reg_rdata` one cycle after `reg_rd`, and leaves the register cleared.
- R6: Writing 1 to a bit of address 1 sets that cause bit for bits 0..30. Bit 31 and bits written as 0 are unaffected.
- R7: Writing 1s to address 2 enables those mask bits, and writing 1s to address 3 disables them. A read of address 2 returns the current mask.
- R8: `irq` equals, one cycle later, the OR over all bits of cause AND mask.
- R9: On the clock edge after `irq` rises, the cause bits enabled in the auto-clear register are cleared. Other bits keep their value.
- R10: When a hardware event and a clear (write-1, read or auto-clear) reach the same bit in the same cycle, the bit ends up set.
- R11: Address 4 holds the auto-clear enable. It is written directly and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronous to clk |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| rx_evt | input | NUM_RXQ | Per-receive-queue event pulses |
| tx_evt | input | NUM_TXQ | Per-transmit-queue event pulses |
| tmr_evt | input | 1 | Timer terminal-count pulse |
| legacy_active | input | 1 | High while any legacy cause is pending |
| irq | output | 1 | Interrupt level |

## Verification
A hardware event can coincide with each of the three clear paths: a write-1 clear, a cause read, or the auto-clear that follows the rise of `irq`. The bench provokes each case by driving the event in the very cycle the clear takes effect. For auto-clear, this is two edges after the set write. A later read then has to show the bit still set. A read that coincides with an event must also return the old value, with the new bit appearing only on the next read.

// File: rtl/icc_pkg.sv
package icc_pkg;

  localparam int TX_BASE = 8;
  localparam int TMR_BIT = 30;
  localparam int LEG_BIT = 31;

  typedef enum logic [2:0] {
    A_CAUSE = 3'd0,
    A_CSET  = 3'd1,
    A_MSET  = 3'd2,
    A_MCLR  = 3'd3,
    A_ACEN  = 3'd4
  } icc_addr_e;

  // Mask of implemented cause bits for a given queue count.
  function automatic logic [31:0] valid_bits(input int nrx, input int ntx);
    logic [31:0] v;
    v = '0;
    for (int i = 0; i < nrx; i++) v[i] = 1'b1;
    for (int i = 0; i < ntx; i++) v[TX_BASE+i] = 1'b1;
    v[TMR_BIT] = 1'b1;
    v[LEG_BIT] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/icc_cause_reg.sv
module icc_cause_reg #(
  parameter logic [31:0] VALID = 32'hFFFF_FFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] hw_set,
  input  logic [31:0] sw_set,
  input  logic [31:0] clr,
  output logic [31:0] cause_q
);

  for (genvar b = 0; b < 32; b++) begin : g_bit
    if (VALID[b]) begin : g_impl
      logic bit_d;
      logic bit_q;
      // set sources override any clear in the same cycle
      always_comb begin
        bit_d = (bit_q & ~clr[b]) | sw_set[b] | hw_set[b];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= bit_d;
      end
      assign cause_q[b] = bit_q;
    end else begin : g_rsvd
      assign cause_q[b] = 1'b0;
    end
  end

endmodule

// File: rtl/icc_mask_reg.sv
module icc_mask_reg #(
  parameter logic [31:0] VALID = 32'hFFFF_FFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mset_we,
  input  logic        mclr_we,
  input  logic        acen_we,
  input  logic [31:0] wdata,
  output logic [31:0] mask_q,
  output logic [31:0] acen_q
);

  logic [31:0] mask_d;
  logic [31:0] acen_d;
  logic        mask_en;

  always_comb begin
    mask_d = mask_q;
    if (mset_we) mask_d = mask_d | (wdata & VALID);
    if (mclr_we) mask_d = mask_d & ~wdata;
    acen_d  = wdata & VALID;
    mask_en = mset_we | mclr_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acen_q <= '0;
    end else if (acen_we) begin
      acen_q <= acen_d;
    end
  end

endmodule

// File: rtl/icc_irq_gen.sv
module icc_irq_gen (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] cause_q,
  input  logic [31:0] mask_q,
  output logic        irq,
  output logic        ac_fire
);

  logic irq_d;
  logic irq_q;
  logic seen_q;

  always_comb begin
    irq_d = |(cause_q & mask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      irq_q  <= irq_d;
      seen_q <= irq_q;
    end
  end

  assign irq     = irq_q;
  assign ac_fire = irq_q & ~seen_q;

endmodule

// File: rtl/intr_cause_ctrl.sv
module intr_cause_ctrl #(
  parameter int NUM_RXQ = 4,
  parameter int NUM_TXQ = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [2:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_RXQ-1:0] rx_evt,
  input  logic [NUM_TXQ-1:0] tx_evt,
  input  logic               tmr_evt,
  input  logic               legacy_active,
  output logic               irq
);
  import icc_pkg::*;

  localparam logic [31:0] VALID  = valid_bits(NUM_RXQ, NUM_TXQ);
  localparam logic [31:0] SW_SET = VALID & ~(32'h1 << LEG_BIT);

  logic [31:0] hw_evt;
  logic [31:0] sw_set;
  logic [31:0] clr;
  logic [31:0] cause_q;
  logic [31:0] mask_q;
  logic [31:0] acen_q;
  logic        ac_fire;
  logic        wr_cause, wr_cset, wr_mset, wr_mclr, wr_acen, rd_cause;
  logic [31:0] rd_mux;
  logic [31:0] rdata_d;
  logic [31:0] rdata_q;

  always_comb begin
    hw_evt = '0;
    for (int i = 0; i < NUM_RXQ; i++) hw_evt[i] = rx_evt[i];
    for (int i = 0; i < NUM_TXQ; i++) hw_evt[TX_BASE+i] = tx_evt[i];
    hw_evt[TMR_BIT] = tmr_evt;
    hw_evt[LEG_BIT] = legacy_active;
  end

  always_comb begin
    wr_cause = reg_wr && (reg_addr == A_CAUSE);
    wr_cset  = reg_wr && (reg_addr == A_CSET);
    wr_mset  = reg_wr && (reg_addr == A_MSET);
    wr_mclr  = reg_wr && (reg_addr == A_MCLR);
    wr_acen  = reg_wr && (reg_addr == A_ACEN);
    rd_cause = reg_rd && (reg_addr == A_CAUSE);
  end

  always_comb begin
    sw_set = wr_cset ? (reg_wdata & SW_SET) : '0;
    clr    = '0;
    if (wr_cause) clr = clr | reg_wdata;
    if (rd_cause) clr = clr | 32'hFFFF_FFFF;
    if (ac_fire)  clr = clr | acen_q;
  end

  icc_cause_reg #(.VALID(VALID)) u_cause (
    .clk     (clk),
    .rst_n   (rst_n),
    .hw_set  (hw_evt & VALID),
    .sw_set  (sw_set),
    .clr     (clr),
    .cause_q (cause_q)
  );

  icc_mask_reg #(.VALID(VALID)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .mset_we (wr_mset),
    .mclr_we (wr_mclr),
    .acen_we (wr_acen),
    .wdata   (reg_wdata),
    .mask_q  (mask_q),
    .acen_q  (acen_q)
  );

  icc_irq_gen u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .cause_q (cause_q),
    .mask_q  (mask_q),
    .irq     (irq),
    .ac_fire (ac_fire)
  );

  always_comb begin
    unique case (reg_addr)
      A_CAUSE: rd_mux = cause_q;
      A_MSET:  rd_mux = mask_q;
      A_ACEN:  rd_mux = acen_q;
      default: rd_mux = '0;
    endcase
    rdata_d = reg_rd ? rd_mux : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign reg_rdata = rdata_q;

endmodule

// File: rtl/icc_checker.sv
module icc_checker #(
  parameter int NUM_RXQ = 4,
  parameter int NUM_TXQ = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic               reg_rd,
  input logic [2:0]         reg_addr,
  input logic [31:0]        reg_wdata,
  input logic [NUM_RXQ-1:0] rx_evt,
  input logic [NUM_TXQ-1:0] tx_evt,
  input logic               tmr_evt,
  input logic               legacy_active,
  input logic               irq,
  input logic [31:0]        cause_q,
  input logic [31:0]        mask_q
);
  import icc_pkg::*;

  localparam logic [31:0] VALID = valid_bits(NUM_RXQ, NUM_TXQ);
  localparam logic [31:0] SWM   = VALID & ~(32'h1 << LEG_BIT);

  logic [31:0] hw;
  always_comb begin
    hw = '0;
    for (int i = 0; i < NUM_RXQ; i++) hw[i] = rx_evt[i];
    for (int i = 0; i < NUM_TXQ; i++) hw[TX_BASE+i] = tx_evt[i];
    hw[TMR_BIT] = tmr_evt;
    hw[LEG_BIT] = legacy_active;
  end

  // R3
  p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((cause_q & ~VALID) == 32'h0) && ((mask_q & ~VALID) == 32'h0));

  // R2 / R10: an event is never lost, whatever clear coincides
  p_event_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hw != 32'h0) |=> ((cause_q & $past(hw)) == $past(hw)));

  // R8
  p_irq_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(cause_q & mask_q))));

  // R4
  p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_CAUSE && hw == 32'h0)
      |=> ((cause_q & $past(reg_wdata)) == 32'h0));

  // R5
  p_read_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_CAUSE && !reg_wr && hw == 32'h0)
      |=> (cause_q == 32'h0));

  // R6
  p_sw_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_CSET)
      |=> ((cause_q & $past(reg_wdata & SWM)) == $past(reg_wdata & SWM)));

  // R6: bit 31 only rises from the legacy input
  p_bit31_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!legacy_active && !cause_q[LEG_BIT]) |=> !cause_q[LEG_BIT]);

  // R7
  p_mask_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_MSET)
      |=> ((mask_q & $past(reg_wdata & VALID)) == $past(reg_wdata & VALID)));

  p_mask_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_MCLR) |=> ((mask_q & $past(reg_wdata)) == 32'h0));

endmodule

bind intr_cause_ctrl icc_checker #(.NUM_RXQ(NUM_RXQ), .NUM_TXQ(NUM_TXQ)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .reg_wr        (reg_wr),
  .reg_rd        (reg_rd),
  .reg_addr      (reg_addr),
  .reg_wdata     (reg_wdata),
  .rx_evt        (rx_evt),
  .tx_evt        (tx_evt),
  .tmr_evt       (tmr_evt),
  .legacy_active (legacy_active),
  .irq           (irq),
  .cause_q       (cause_q),
  .mask_q        (mask_q)
);

// File: tb/intr_cause_ctrl_test.sv
module intr_cause_ctrl_test;

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic        reg_rd;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [3:0]  rx_evt;
  logic [3:0]  tx_evt;
  logic        tmr_evt;
  logic        legacy_active;
  logic        irq;

  int tests  = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  intr_cause_ctrl #(.NUM_RXQ(4), .NUM_TXQ(4)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_evt(rx_evt), .tx_evt(tx_evt), .tmr_evt(tmr_evt),
    .legacy_active(legacy_active), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  // driver: issues the read and queues the expected word
  task automatic rd_reg(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic pulse(input logic [3:0] rx, input logic [3:0] tx,
                       input logic tm, input logic lg);
    @(negedge clk);
    rx_evt = rx; tx_evt = tx; tmr_evt = tm; legacy_active = lg;
    @(negedge clk);
    rx_evt = '0; tx_evt = '0; tmr_evt = 1'b0; legacy_active = 1'b0;
  endtask

  // monitor: compares read data the cycle after each read strobe
  initial begin
    forever begin
      @(posedge clk);
      if (reg_rd) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          check("scoreboard underflow", reg_rdata, 32'hx);
        end else begin
          check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    rx_evt = '0; tx_evt = '0; tmr_evt = 1'b0; legacy_active = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    rd_reg(3'd0, 32'h0, "R1 cause after reset");
    rd_reg(3'd2, 32'h0, "R1 mask after reset");
    rd_reg(3'd4, 32'h0, "R1 acen after reset");

    // R2 event mapping, R5 read clears
    pulse(4'b0101, 4'b1000, 1'b1, 1'b1);
    rd_reg(3'd0, 32'hC000_0805, "R2 event mapping");
    rd_reg(3'd0, 32'h0, "R5 read cleared cause");

    // R6 software set, bit 31 ignored; R3 reserved stay 0
    wr_reg(3'd1, 32'hFFFF_FFFF);
    rd_reg(3'd0, 32'h4000_0F0F, "R6 R3 set-all leaves bit31 and reserved clear");

    // R4 write one to clear
    wr_reg(3'd1, 32'h0000_0F0F);
    wr_reg(3'd0, 32'h0000_0005);
    wr_reg(3'd0, 32'h0000_0000);
    rd_reg(3'd0, 32'h0000_0F0A, "R4 w1c clears ones only");

    // R7 mask set/clear, R3 on mask
    wr_reg(3'd2, 32'hFFFF_FFFF);
    rd_reg(3'd2, 32'hC000_0F0F, "R7 R3 mask set readback");
    wr_reg(3'd3, 32'h8000_0F00);
    rd_reg(3'd2, 32'h4000_000F, "R7 mask clear readback");

    // R8 irq gating and latency
    wr_reg(3'd1, 32'h0000_0100);
    idle(2);
    check("R8 masked cause gives no irq", {31'b0, irq}, 32'h0);
    wr_reg(3'd1, 32'h0000_0002);
    check("R8 irq registered one cycle late", {31'b0, irq}, 32'h0);
    idle(1);
    check("R8 irq asserted", {31'b0, irq}, 32'h1);
    rd_reg(3'd0, 32'h0000_0102, "R5 cause read with irq");
    idle(1);
    check("R8 irq drops after read clear", {31'b0, irq}, 32'h0);

    // R11 auto-clear enable register
    wr_reg(3'd4, 32'hFFFF_FFFF);
    rd_reg(3'd4, 32'hC000_0F0F, "R11 R3 acen readback");
    wr_reg(3'd4, 32'h0000_0003);
    rd_reg(3'd4, 32'h0000_0003, "R11 acen rewrite");

    // R9 auto-clear after irq rises
    idle(2);
    wr_reg(3'd1, 32'h0000_0103);
    idle(1);
    check("R9 irq before auto-clear", {31'b0, irq}, 32'h1);
    idle(3);
    check("R9 irq low after auto-clear", {31'b0, irq}, 32'h0);
    rd_reg(3'd0, 32'h0000_0100, "R9 only enabled bits auto-cleared");

    // R10 event against write-one-to-clear
    idle(2);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h4; rx_evt = 4'b0100;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; rx_evt = '0;
    rd_reg(3'd0, 32'h0000_0004, "R10 event beats w1c");

    // R10 event against read clear
    idle(2);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 3'd0; rx_evt = 4'b1000;
    exp_q.push_back(32'h0); tag_q.push_back("R10 read returns old value");
    @(negedge clk);
    reg_rd = 1'b0; rx_evt = '0;
    rd_reg(3'd0, 32'h0000_0008, "R10 event beats read clear");

    // R10 event against auto-clear
    wr_reg(3'd4, 32'h0000_000F);
    idle(3);
    wr_reg(3'd1, 32'h0000_0001);
    @(negedge clk);
    rx_evt = 4'b0001;
    @(negedge clk);
    rx_evt = '0;
    idle(3);
    check("R10 R8 irq held by surviving bit", {31'b0, irq}, 32'h1);
    rd_reg(3'd0, 32'h0000_0001, "R10 event beats auto-clear");
    idle(2);
    check("R8 irq low at end", {31'b0, irq}, 32'h0);

    idle(3);
    if (exp_q.size() != 0) check("scoreboard drain", exp_q.size(), 32'h0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule